// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Store

This block is the read side of a configuration memory that feeds a bitstream into a programmable logic device. A preload port fills a byte array. After that, each rising clock edge steps an internal read pointer by one output unit. The unit is one bit in serial mode and one byte in byte-wide mode, and the pointer only moves while the chip is selected and its output is enabled. Serial streams send each stored byte most-significant bit first. The output always shows the unit at the current pointer, before the edge that moves it.

A single pin carries both reset and output enable. A parameter picks its polarity: with the default setting a high level resets, and with the other setting a low level resets. While the pin is in reset, the pointer is forced to zero at once and the outputs are released. A hold input freezes the stream, and a separate enable input decides whether the hold pin is obeyed at all. A cascade output goes low once the whole stream has been read. It is meant to select the next device in a chain.

Top module: `bitstream_prom`

## Requirements
- R1: While `ceN` is low, the enable side of `rstOe` is active and the store is not held, each rising clock edge moves the output to the next unit.
- R2: While `rstOe` is in its reset state, the pointer returns to zero without waiting for a clock, `dataOe` is 0 and `ceoN` is 1.
- R3: With `RST_ACTIVE_HIGH`=1, a high `rstOe` means reset and a low one means enable. With `RST_ACTIVE_HIGH`=0, a low `rstOe` means reset and a high one means enable.
- R4: While `ceN` is high, the pointer does not move and `dataOe` is 0.
- R5: Whenever the chip is deselected or output enable is inactive, `dataOe` is 0 and `data` is all zeros.
- R6: `ceoN` is 0 only when `ceN` is low, output enable is active and the pointer has passed the last unit. Once past the end, `ceoN` follows `ceN`, and `data` reads zero while it is driven.
- R7: After a reset, `ceoN` stays 1, even with the output enabled again, until the full stream has been read once more.
- R8: While `busy` is 1 and `busyUse` is 1, the pointer and `data` hold their values. Streaming resumes on the first edge after `busy` falls.
- R9: While `busyUse` is 0, the `busy` pin has no effect and the stream advances as in R1.
- R10: In serial mode (`WIDE`=0), `data[0]` carries bit 7 of byte 0 first, then bit 6 of byte 0, and so on down to bit 0 of the last byte.
- R11: In byte mode (`WIDE`=1), `data` equals the stored byte at the current pointer, starting at byte 0.
- R12: The pointer stops one past the last unit (TC+1, where TC is the number of units minus one). Further enabled clocks do not wrap it.
- R13: A rising edge with `wrEn`=1 stores `wrData` at byte `wrAddr`. Reading it back gives that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| rstOe | input | 1 | Combined reset / output enable; polarity set by `RST_ACTIVE_HIGH` |
| ceN | input | 1 | Chip select, active low |
| busy | input | 1 | Stream hold request |
| busyUse | input | 1 | 1 makes `busy` take effect |
| wrEn | input | 1 | Preload write strobe |
| wrAddr | input | clog2(NUM_BYTES) | Preload byte address |
| wrData | input | 8 | Preload byte |
| data | output | 1 or 8 | Stream output unit (zero when not driven) |
| dataOe | output | 1 | 1 when `data` is driven |
| ceoN | output | 1 | Cascade select for the next device, active low |

## Verification
`data`, `dataOe` and `ceoN` depend combinationally on the pins and the current pointer. The bench therefore changes inputs on a falling edge and samples 1 ns later, before the rising edge that acts on them. A pointer step that a rising edge causes becomes visible at the next falling-edge sample, which is exactly one cycle later. Reset is asynchronous, so its effect on the outputs is checked 1 ns after the pin changes, with no clock edge in between.

// File: rtl/bprom_pkg.sv
package bprom_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
    logic drive;
  } ctlStrobe_t;
endpackage

// File: rtl/bprom_ctrl.sv
module bprom_ctrl
  import bprom_pkg::*;
#(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       rstOe,
  input  logic       ceN,
  input  logic       busy,
  input  logic       busyUse,
  input  logic       atEnd,
  output ctlStrobe_t strobe,
  output logic       ceoN
);
  logic rstHit;
  logic oeOn;
  logic ceOn;
  logic holdOn;

  // Polarity of the shared reset / enable pin is fixed at build time.
  generate
    if (RST_ACTIVE_HIGH) begin : g_rstHigh
      assign rstHit = rstOe;
    end else begin : g_rstLow
      assign rstHit = ~rstOe;
    end
  endgenerate

  assign oeOn   = ~rstHit;
  assign ceOn   = ~ceN;
  assign holdOn = busy & busyUse;

  always_comb begin
    strobe.clear   = rstHit;
    strobe.drive   = ceOn & oeOn;
    strobe.advance = ceOn & oeOn & ~holdOn & ~atEnd;
    ceoN           = ~(ceOn & oeOn & atEnd);
  end
endmodule

// File: rtl/bprom_datapath.sv
module bprom_datapath
  import bprom_pkg::*;
#(
  parameter int NUM_BYTES = 64,
  parameter bit WIDE      = 1'b0,
  localparam int DW       = WIDE ? 8 : 1,
  localparam int UNITS    = WIDE ? NUM_BYTES : NUM_BYTES * 8,
  localparam int AW       = $clog2(UNITS + 1),
  localparam int BAW      = $clog2(NUM_BYTES)
) (
  input  logic           clk,
  input  ctlStrobe_t     strobe,
  input  logic           wrEn,
  input  logic [BAW-1:0] wrAddr,
  input  logic [7:0]     wrData,
  output logic [DW-1:0]  data,
  output logic           dataOe,
  output logic [AW-1:0]  addr,
  output logic           atEnd
);
  logic [7:0]    store [NUM_BYTES];
  logic          clrAsync;
  logic [DW-1:0] unitSel;
  logic [BAW-1:0] byteIdx;

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  assign clrAsync = strobe.clear;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync)            addr <= '0;
    else if (strobe.advance) addr <= addr + 1'b1;
  end

  assign atEnd = (addr == AW'(UNITS));

  generate
    if (WIDE) begin : g_byte
      assign byteIdx = BAW'(addr);
      assign unitSel = store[byteIdx];
    end else begin : g_serial
      logic [2:0] bitPos;
      logic [7:0] curByte;
      assign byteIdx = BAW'(addr >> 3);
      assign bitPos  = 3'd7 - addr[2:0];
      assign curByte = store[byteIdx];
      assign unitSel = curByte[bitPos];
    end
  endgenerate

  assign dataOe = strobe.drive;
  assign data   = (strobe.drive && !atEnd) ? unitSel : '0;
endmodule

// File: rtl/bitstream_prom.sv
module bitstream_prom
  import bprom_pkg::*;
#(
  parameter int NUM_BYTES       = 64,
  parameter bit WIDE            = 1'b0,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstOe,
  input  logic                         ceN,
  input  logic                         busy,
  input  logic                         busyUse,
  input  logic                         wrEn,
  input  logic [$clog2(NUM_BYTES)-1:0] wrAddr,
  input  logic [7:0]                   wrData,
  output logic [(WIDE ? 8 : 1)-1:0]    data,
  output logic                         dataOe,
  output logic                         ceoN
);
  localparam int UNITS = WIDE ? NUM_BYTES : NUM_BYTES * 8;
  localparam int AW    = $clog2(UNITS + 1);

  ctlStrobe_t    strobe;
  logic          atEnd;
  logic [AW-1:0] addr;

  bprom_ctrl #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) ctrl_i (
    .rstOe   (rstOe),
    .ceN     (ceN),
    .busy    (busy),
    .busyUse (busyUse),
    .atEnd   (atEnd),
    .strobe  (strobe),
    .ceoN    (ceoN)
  );

  bprom_datapath #(.NUM_BYTES(NUM_BYTES), .WIDE(WIDE)) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .data   (data),
    .dataOe (dataOe),
    .addr   (addr),
    .atEnd  (atEnd)
  );
endmodule

// File: rtl/bprom_checker.sv
module bprom_checker #(
  parameter int NUM_BYTES       = 64,
  parameter bit WIDE            = 1'b0,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int DW             = WIDE ? 8 : 1,
  localparam int UNITS          = WIDE ? NUM_BYTES : NUM_BYTES * 8,
  localparam int AW             = $clog2(UNITS + 1)
) (
  input logic          clk,
  input logic          rstOe,
  input logic          ceN,
  input logic          busy,
  input logic          busyUse,
  input logic [DW-1:0] data,
  input logic          dataOe,
  input logic          ceoN,
  input logic [AW-1:0] addr
);
  logic rstHit;
  logic selOn;
  assign rstHit = RST_ACTIVE_HIGH ? rstOe : ~rstOe;
  assign selOn  = ~ceN & ~rstHit;

  always_comb begin
    if (rstHit) begin
      p_reset_quiet_r2: assert (!dataOe && ceoN);
    end
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rstHit)
    (selOn && !(busy && busyUse) && addr != AW'(UNITS)) |=> addr == AW'($past(addr) + 1'b1));

  p_ce_freeze_r4: assert property (@(posedge clk) disable iff (rstHit)
    ceN |=> $stable(addr));

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (rstHit)
    !selOn |-> (!dataOe && data == '0));

  p_cascade_r6: assert property (@(posedge clk) disable iff (rstHit)
    !ceoN |-> (selOn && addr == AW'(UNITS) && data == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rstHit)
    (busy && busyUse) |=> $stable(addr));

  p_no_wrap_r12: assert property (@(posedge clk) disable iff (rstHit)
    addr <= AW'(UNITS));
endmodule

bind bitstream_prom bprom_checker #(
  .NUM_BYTES(NUM_BYTES), .WIDE(WIDE), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) chk_i (.*);

// File: tb/bitstream_prom_tb_top.sv
`timescale 1ns/1ps
module bitstream_prom_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // serial device: 2 bytes, reset active high
  logic sRst, sCeN, sBusy, sUse, sWrEn;
  logic [0:0] sWrAddr;
  logic [7:0] sWrData;
  logic [0:0] sData;
  logic sOe, sCeo;

  // byte device: 4 bytes, reset active low
  logic bRst, bCeN, bBusy, bUse, bWrEn;
  logic [1:0] bWrAddr;
  logic [7:0] bWrData;
  logic [7:0] bData;
  logic bOe, bCeo;

  bitstream_prom #(.NUM_BYTES(2), .WIDE(1'b0), .RST_ACTIVE_HIGH(1'b1)) dut_i (
    .clk(clk), .rstOe(sRst), .ceN(sCeN), .busy(sBusy), .busyUse(sUse),
    .wrEn(sWrEn), .wrAddr(sWrAddr), .wrData(sWrData),
    .data(sData), .dataOe(sOe), .ceoN(sCeo));

  bitstream_prom #(.NUM_BYTES(4), .WIDE(1'b1), .RST_ACTIVE_HIGH(1'b0)) dutB_i (
    .clk(clk), .rstOe(bRst), .ceN(bCeN), .busy(bBusy), .busyUse(bUse),
    .wrEn(bWrEn), .wrAddr(bWrAddr), .wrData(bWrData),
    .data(bData), .dataOe(bOe), .ceoN(bCeo));

  localparam logic [15:0] SSTREAM = 16'hA53C;

  function automatic logic sBit(int k);
    return SSTREAM[15 - k];
  endfunction

  function automatic logic [7:0] bByte(int i);
    return 8'h3C ^ (8'(i) * 8'h25);
  endfunction

  // row: [7] ceN [6] busy [5] busyUse [4:2] pointer [1] expected dataOe [0] expected ceoN
  localparam int NROWS = 10;
  localparam logic [7:0] VEC [NROWS] = '{
    8'b00100011,  // R1 advance from 0
    8'b10100101,  // R4 deselected, frozen at 1
    8'b01100111,  // R8 held at 1
    8'b01000111,  // R9 busy ignored, advance
    8'b00101011,  // R11 byte 2
    8'b00101111,  // R11 last byte
    8'b00110010,  // R6 past end
    8'b00110010,  // R12 saturated
    8'b10110001,  // R6 ceoN follows ceN
    8'b00110010   // R6 low again
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sRst = 1'b1; sCeN = 1'b0; sBusy = 1'b0; sUse = 1'b1; sWrEn = 1'b0;
    sWrAddr = '0; sWrData = '0;
    bRst = 1'b0; bCeN = 1'b1; bBusy = 1'b0; bUse = 1'b1; bWrEn = 1'b0;
    bWrAddr = '0; bWrData = '0;

    // R13 preload
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sWrEn = (i < 2); sWrAddr = 1'(i); sWrData = SSTREAM[15 - 8*(i%2) -: 8];
      bWrEn = 1'b1;    bWrAddr = 2'(i); bWrData = bByte(i);
    end
    @(negedge clk);
    sWrEn = 1'b0; bWrEn = 1'b0;
    #1;
    check("R2 serial dataOe in reset", sOe, 0);
    check("R2 serial ceoN in reset", sCeo, 1);
    check("R5 serial data in reset", sData, 0);
    check("R3 low-level reset dataOe", bOe, 0);
    check("R2 byte ceoN in reset", bCeo, 1);

    // serial walk with a two-cycle hold in the middle
    @(negedge clk);
    sRst = 1'b0;
    #1;
    check("R3 high-polarity pin low enables", sOe, 1);
    begin
      int k = 0;
      for (int c = 0; c < 18; c++) begin
        check((c == 7 || c == 8) ? "R8 hold keeps data" : "R10 serial bit order", sData, sBit(k));
        check("R6 ceoN high mid stream", sCeo, 1);
        sBusy = (c == 6 || c == 7);
        @(negedge clk);
        #1;
        if (!(c == 6 || c == 7)) k++;
      end
    end
    sBusy = 1'b0;
    check("R6 ceoN low past end", sCeo, 0);
    check("R6 data zero past end", sData, 0);
    check("R6 dataOe past end", sOe, 1);
    repeat (3) @(negedge clk);
    #1;
    check("R12 no wrap ceoN", sCeo, 0);
    check("R12 no wrap data", sData, 0);
    sCeN = 1'b1;
    #1;
    check("R6 ceoN follows ceN", sCeo, 1);
    check("R4 dataOe off when deselected", sOe, 0);
    repeat (2) @(negedge clk);
    sCeN = 1'b0;
    #1;
    check("R4 pointer frozen while deselected", sCeo, 0);
    @(negedge clk);
    sRst = 1'b1;
    #1;
    check("R2 async reset dataOe", sOe, 0);
    check("R2 async reset ceoN", sCeo, 1);
    @(negedge clk);
    sRst = 1'b0;
    #1;
    check("R7 ceoN stays high after reset", sCeo, 1);
    check("R2 pointer back to zero", sData, sBit(0));
    @(negedge clk);
    #1;
    check("R7 ceoN high while rereading", sCeo, 1);
    check("R1 serial advance after reset", sData, sBit(1));
    sCeN = 1'b1;

    // byte device table
    @(negedge clk);
    bRst = 1'b1;
    #1;
    check("R4 byte deselected dataOe", bOe, 0);
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] row;
      int pAddr;
      int expD;
      row = VEC[r];
      bCeN = row[7]; bBusy = row[6]; bUse = row[5];
      pAddr = int'(row[4:2]);
      #1;
      expD = (row[1] && pAddr < 4) ? int'(bByte(pAddr)) : 0;
      check($sformatf("R11 row %0d data", r), bData, expD);
      check($sformatf("R5 row %0d dataOe", r), bOe, int'(row[1]));
      check($sformatf("R6 row %0d ceoN", r), bCeo, int'(row[0]));
      @(negedge clk);
    end
    bBusy = 1'b0; bUse = 1'b1;
    bRst = 1'b0;
    #1;
    check("R3 low-level reset quiets output", bOe, 0);
    check("R2 byte reset ceoN", bCeo, 1);
    @(negedge clk);
    bRst = 1'b1;
    #1;
    check("R7 byte ceoN after reset", bCeo, 1);
    check("R11 byte restart at 0", bData, bByte(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule